// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a 32-bit down-counter that software controls through six 16-bit registers. Software stores a period and picks a mode, then starts the counter. The counter steps down by one each clock. When it has counted past zero, it raises a timeout flag, drives a one-cycle pulse and, if enabled, asserts an interrupt. In one-shot mode the counter stops after the first timeout. In continuous mode it reloads the period and carries on.

Any write to a period half stops the counter and loads it, so a new period always takes effect from a clean start. Software cannot read two halves of a moving count coherently, so a write to either snapshot half first copies the whole count into a holding register. Both halves can then be read at leisure. The interrupt is acknowledged in one of two ways: clear the flag, or drop the enable bit.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter is stopped and status reads 0. Control reads 0, both snapshot halves read 0, and the period halves read the low and high halves of the parameter DEF_PERIOD. irq and timeoutPulse are low.
- R2: Register word addresses are: 0 status (bit 0 timeout flag, bit 1 running); 1 control (bit 0 interrupt enable, bit 1 continuous mode); 2 period low; 3 period high; 4 snapshot low; 5 snapshot high. Period halves read back as written. Control bits 2 and up always read zero.
- R3: A write to either period half loads the counter with the new full period and clears the running bit in the same cycle.
- R4: Writing control bit 2 as 1 starts the counter and writing control bit 3 as 1 stops it. Neither bit is stored. When both are written as 1 together, stop wins.
- R5: With period value P, the first timeoutPulse appears P+1 cycles after the clock edge that accepted the start write.
- R6: In one-shot mode (control bit 1 = 0) the counter stops after a timeout and reloads the period, so a later start again takes P+1 cycles.
- R7: In continuous mode (control bit 1 = 1) timeouts repeat every P+1 cycles until a stop write.
- R8: Each timeout sets the status timeout flag and drives timeoutPulse high for exactly one cycle.
- R9: irq is high while the timeout flag and the interrupt enable are both 1. Any write to the status register clears the flag and with it irq.
- R10: Clearing the interrupt enable drops irq while the timeout flag stays set.
- R11: A write of any data to either snapshot half copies the full count that was current before that clock edge into both halves at once. The halves then hold that value while the counter keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for busAddr, combinational |
| irq | output | 1 | Interrupt request |
| timeoutPulse | output | 1 | One-cycle pulse on each timeout |

## Verification
The bench builds the timer with a DEF_PERIOD whose two halves differ, 0x0003_0007, so the reset readback shows each half in its own register. It then loads short periods of 5 and 9, which let one-shot, continuous and restart sequences complete within a few dozen cycles. Each expected pulse cycle is checked exactly against the P+1 rule. A 0x0001_0000 period makes the snapshot span the boundary between the halves, so a capture that lost coherence between the low and high words would show up.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Fixed word addresses of the two control-plane registers
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int PERIOD_BASE = 2;

  // Control bit positions
  localparam int BIT_IE    = 0;
  localparam int BIT_CONT  = 1;
  localparam int BIT_START = 2;
  localparam int BIT_STOP  = 3;

  // Strobes from register control to the counting datapath
  typedef struct packed {
    logic load;   // period write: reload and halt
    logic start;  // start strobe
    logic stop;   // stop strobe
    logic snap;   // capture count into snapshot
    logic cont;   // continuous mode level
  } tmrStrobes_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [CNT_W-1:0] DEF_PERIOD = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic              cntRun,
  input  logic              hitEvent,
  input  logic [CNT_W-1:0]  snapVal,
  output tmrStrobes_t       strobes,
  output logic [CNT_W-1:0]  periodNext,
  output logic              irq
);
  localparam int NUM_HALVES = CNT_W / REG_W;
  localparam int SNAP_BASE  = PERIOD_BASE + NUM_HALVES;

  logic [REG_W-1:0] periodHalf [NUM_HALVES];
  logic [CNT_W-1:0] periodNow;
  logic [NUM_HALVES-1:0] periodWrHit;
  logic [NUM_HALVES-1:0] snapWrHit;
  logic ieBit, contBit, toFlag;
  logic wrStatus, wrCtrl;

  assign wrStatus = busWrEn && (busAddr == ADDR_W'(ADDR_STATUS));
  assign wrCtrl   = busWrEn && (busAddr == ADDR_W'(ADDR_CTRL));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_HALVES; gi++) begin : g_half
      localparam logic [ADDR_W-1:0] P_ADDR = ADDR_W'(PERIOD_BASE + gi);
      localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(SNAP_BASE + gi);
      assign periodWrHit[gi] = busWrEn && (busAddr == P_ADDR);
      assign snapWrHit[gi]   = busWrEn && (busAddr == S_ADDR);
      always_ff @(posedge clk) begin
        if (!rstN) periodHalf[gi] <= DEF_PERIOD[gi*REG_W +: REG_W];
        else if (periodWrHit[gi]) periodHalf[gi] <= busWrData;
      end
      assign periodNow[gi*REG_W +: REG_W]  = periodHalf[gi];
      assign periodNext[gi*REG_W +: REG_W] = periodWrHit[gi] ? busWrData : periodHalf[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieBit   <= 1'b0;
      contBit <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ieBit   <= busWrData[BIT_IE];
        contBit <= busWrData[BIT_CONT];
      end
      if (hitEvent) toFlag <= 1'b1;
      else if (wrStatus) toFlag <= 1'b0;
    end
  end

  assign strobes.load  = |periodWrHit;
  assign strobes.start = wrCtrl && busWrData[BIT_START];
  assign strobes.stop  = wrCtrl && busWrData[BIT_STOP];
  assign strobes.snap  = |snapWrHit;
  assign strobes.cont  = contBit;

  assign irq = toFlag && ieBit;

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(ADDR_STATUS)) busRdData = {{(REG_W-2){1'b0}}, cntRun, toFlag};
    if (busAddr == ADDR_W'(ADDR_CTRL))   busRdData = {{(REG_W-2){1'b0}}, contBit, ieBit};
    for (int i = 0; i < NUM_HALVES; i++) begin
      if (busAddr == ADDR_W'(PERIOD_BASE + i)) busRdData = periodNow[i*REG_W +: REG_W];
      if (busAddr == ADDR_W'(SNAP_BASE + i))   busRdData = snapVal[i*REG_W +: REG_W];
    end
  end

  // R8
  to_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitEvent |=> toFlag);
  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && !hitEvent) |=> !irq);
  // R10
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !busWrData[BIT_IE]) |=> !irq);

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] DEF_PERIOD = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [CNT_W-1:0] periodNext,
  output logic             cntRun,
  output logic             hitEvent,
  output logic [CNT_W-1:0] snapVal,
  output logic             timeoutPulse
);
  logic [CNT_W-1:0] cnt;
  logic runReg;

  // A running counter that sits at zero times out unless a period write overrides it
  assign hitEvent = runReg && (cnt == '0) && !strobes.load;
  assign cntRun   = runReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt          <= DEF_PERIOD;
      runReg       <= 1'b0;
      snapVal      <= '0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= hitEvent;
      if (strobes.snap) snapVal <= cnt;
      if (strobes.load) begin
        cnt    <= periodNext;
        runReg <= 1'b0;
      end else begin
        if (hitEvent) begin
          cnt <= periodNext;
          if (!strobes.cont) runReg <= 1'b0;
        end else if (runReg) begin
          cnt <= cnt - 1'b1;
        end
        if (strobes.start) runReg <= 1'b1;
        if (strobes.stop)  runReg <= 1'b0;
      end
    end
  end

  // R3
  load_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (!runReg && cnt == $past(periodNext)));
  // R4
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stop |=> !runReg);
  // R6
  one_shot_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitEvent && !strobes.cont && !strobes.start) |=> !runReg);
  // R11
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.snap |=> (snapVal == $past(cnt)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 2 * REG_W,
  parameter int ADDR_W = 3,
  parameter logic [CNT_W-1:0] DEF_PERIOD = CNT_W'(100000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic              irq,
  output logic              timeoutPulse
);
  tmrStrobes_t      strobes;
  logic [CNT_W-1:0] periodNext, snapVal;
  logic             cntRun, hitEvent;

  tick_timer_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DEF_PERIOD(DEF_PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cntRun(cntRun),
    .hitEvent(hitEvent), .snapVal(snapVal), .strobes(strobes),
    .periodNext(periodNext), .irq(irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .periodNext(periodNext),
    .cntRun(cntRun), .hitEvent(hitEvent), .snapVal(snapVal),
    .timeoutPulse(timeoutPulse)
  );

endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic irq, timeoutPulse;

  int errors = 0;
  int checks = 0;
  int unsigned cyc = 0;
  int unsigned wrCyc = 0;
  int unsigned expQ[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer #(.REG_W(16), .CNT_W(32), .ADDR_W(3), .DEF_PERIOD(32'h0003_0007)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
    .timeoutPulse(timeoutPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1;
    wrCyc = cyc;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, {16'h0, v}, {16'h0, exp});
  endtask

  // Monitor: every pulse must match the next expected cycle (R5, R7, R8)
  always @(negedge clk) begin
    if (rstN && timeoutPulse) begin
      if (expQ.size() == 0) begin
        chk("R8 unexpected pulse", {31'h0, timeoutPulse}, 32'h0);
      end else begin
        int unsigned e;
        e = expQ.pop_front();
        chk("R5 pulse cycle", cyc, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned c0, cs;
    logic [31:0] expSnap;
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk("R1 status", 3'd0, 16'h0000);
    rdChk("R1 control", 3'd1, 16'h0000);
    rdChk("R1 period low", 3'd2, 16'h0007);
    rdChk("R1 period high", 3'd3, 16'h0003);
    rdChk("R1 snap low", 3'd4, 16'h0000);
    rdChk("R1 snap high", 3'd5, 16'h0000);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 / R4: upper control bits read zero, stop beats start
    wr(3'd1, 16'hFFFF);
    rdChk("R2 control readback", 3'd1, 16'h0003);
    rdChk("R4 stop wins", 3'd0, 16'h0000);
    wr(3'd1, 16'h0000);

    // R2 / R3 period load
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd0);
    rdChk("R2 period low", 3'd2, 16'd5);
    rdChk("R2 period high", 3'd3, 16'd0);
    rdChk("R3 stopped after load", 3'd0, 16'h0000);

    // One-shot with interrupt (R4, R5, R6, R8, R9)
    wr(3'd1, 16'h0005);
    expQ.push_back(wrCyc + 6);
    rdChk("R4 running", 3'd0, 16'h0002);
    repeat (10) @(negedge clk);
    rdChk("R6 one-shot stopped, flag set", 3'd0, 16'h0001);
    chk("R9 irq set", {31'h0, irq}, 32'h1);
    wr(3'd0, 16'h1234);
    #1;
    chk("R9 irq cleared by status write", {31'h0, irq}, 32'h0);
    rdChk("R9 flag cleared", 3'd0, 16'h0000);

    // R6 reload: second one-shot takes P+1 again
    wr(3'd1, 16'h0005);
    expQ.push_back(wrCyc + 6);
    repeat (10) @(negedge clk);
    rdChk("R6 second one-shot", 3'd0, 16'h0001);

    // R10 clear by dropping enable
    wr(3'd1, 16'h0000);
    #1;
    chk("R10 irq cleared by enable", {31'h0, irq}, 32'h0);
    rdChk("R10 flag kept", 3'd0, 16'h0001);
    wr(3'd0, 16'h0000);

    // R7 continuous mode
    wr(3'd1, 16'h0007);
    c0 = wrCyc;
    expQ.push_back(c0 + 6);
    expQ.push_back(c0 + 12);
    while (cyc < c0 + 14) @(negedge clk);
    wr(3'd1, 16'h000B);
    rdChk("R7 stopped, flag set", 3'd0, 16'h0001);
    chk("R7 all pulses seen", expQ.size(), 32'd0);
    wr(3'd0, 16'h0000);

    // R3 period write halts a running counter
    wr(3'd1, 16'h0006);
    wr(3'd2, 16'd9);
    rdChk("R3 period write stops", 3'd0, 16'h0000);
    repeat (20) @(negedge clk);
    chk("R3 no pulse while stopped", expQ.size(), 32'd0);
    wr(3'd1, 16'h0006);
    expQ.push_back(wrCyc + 10);
    repeat (12) @(negedge clk);
    wr(3'd1, 16'h0008);
    chk("R5 period 9 pulse seen", expQ.size(), 32'd0);
    wr(3'd0, 16'h0000);

    // R11 coherent snapshot across the half boundary
    wr(3'd2, 16'h0000);
    wr(3'd3, 16'h0001);
    wr(3'd1, 16'h0004);
    c0 = wrCyc;
    wr(3'd4, 16'hABCD);
    cs = wrCyc;
    expSnap = 32'h0001_0000 - (cs - 1 - c0);
    rdChk("R11 snap low", 3'd4, expSnap[15:0]);
    rdChk("R11 snap high", 3'd5, expSnap[31:16]);
    repeat (5) @(negedge clk);
    wr(3'd5, 16'h0000);
    cs = wrCyc;
    expSnap = 32'h0001_0000 - (cs - 1 - c0);
    rdChk("R11 second snap low", 3'd4, expSnap[15:0]);
    rdChk("R11 second snap high", 3'd5, expSnap[31:16]);
    repeat (3) @(negedge clk);
    rd(3'd4, v);
    chk("R11 snap holds", {16'h0, v}, {16'h0, expSnap[15:0]});
    wr(3'd1, 16'h0008);

    repeat (4) @(negedge clk);
    chk("R8 no pending pulses", expQ.size(), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule